// File: doc/BRIEF.md
# Host Byte Port with Request Handshake

This block connects an 8-bit host bus to a 16-bit data register and a 16-bit status word inside a signal-processing core. The host drives active-low strobes that the block samples once per clock: a chip select, an address line that picks data or status, read and write strobes, and a DMA acknowledge. The DMA acknowledge selects the data register by itself. The data register moves either as a single byte or as two bytes in sequence. A status bit records which byte comes next.

The core loads the data register, takes its value with a read that sets the request flag, or samples it with a no-flag read that leaves the flag alone. It also writes a 9-bit control word. The control word holds the DMA enable, the byte-width selects for the data register and the two serial channels, the interrupt enable, two user flags and two output pins. A request flag passes the data register between the core and the host. When DMA is enabled, the flag also drives a DMA request line.

Top module: `hostport`

## Requirements
- R1: While the chip select and the DMA acknowledge are both high, or while neither strobe is low, the output enable `hdoe` stays low and no host transfer takes place.
- R2: A data write (chip select low, `ha0`=0, only `hwr_n` low) stores the byte held on `hdin` during the last low cycle of the strobe into the current byte lane. The store takes effect at the clock edge on which the strobe is first seen high again.
- R3: A data read drives the current byte lane on `hdout` with `hdoe`=1 for as long as the strobe is low. The byte sequence advances when the strobe ends.
- R4: A status read (chip select low, `ha0`=1, only `hrd_n` low) returns `stat_word[15:8]`. A write with `ha0`=1 changes nothing.
- R5: Read and write strobes low together form an illegal access. It drives nothing and changes no state.
- R6: `hack_n` low selects the data register exactly as chip select low with `ha0`=0 does, whatever `hcs_n` and `ha0` are.
- R7: In two-byte mode (width bit 0), the low byte moves first. The next-byte bit becomes 1 after the first byte and returns to 0 after the second. It can only rise in two-byte mode.
- R8: In one-byte mode (width bit 1), every transfer uses the low byte. The next-byte bit stays 0, and a host write leaves the high byte unchanged.
- R9: A core load or a flag-setting core read sets the request flag and clears the next-byte bit on the following edge. The no-flag read (`core_peek`) only captures the register into `core_rdata`.
- R10: The request flag falls only when the host completes the final byte of a transfer.
- R11: The status word holds, from bit 15 down: request, user flag 1, user flag 0, next-byte, DMA enable, data width, serial-out width, serial-in width. Interrupt enable is bit 7, P1 is bit 1, P0 is bit 0, and all other bits are 0. `ctl_in` bits 8..0 are user flag 1, user flag 0, DMA, data width, serial-out width, serial-in width, interrupt enable, P1, P0.
- R12: `port_p0` and `port_p1` follow the P0 and P1 control bits directly.
- R13: `hreq` is high only while DMA is enabled and the request flag is set. It drops as soon as a strobe qualified by `hack_n` is seen on the final byte.
- R14: If a core load or flag-setting read falls on the same edge as the host completing a final byte, the core wins: the request flag ends at 1 and the next-byte bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| hcs_n | input | 1 | Host chip select, active low |
| ha0 | input | 1 | Host address: 0 data, 1 status |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| hack_n | input | 1 | DMA acknowledge, active low, selects data |
| hdin | input | 8 | Host write byte |
| hdout | output | 8 | Host read byte |
| hdoe | output | 1 | Host bus output enable |
| hreq | output | 1 | DMA request |
| core_ld | input | 1 | Core load of the data register |
| core_ldata | input | 16 | Core load value |
| core_rd | input | 1 | Core read that sets the request flag |
| core_peek | input | 1 | Core read that leaves the request flag |
| core_rdata | output | 16 | Data register captured by a core read |
| ctl_we | input | 1 | Control word write |
| ctl_in | input | 9 | Control word value (R11 layout) |
| stat_word | output | 16 | Full status word |
| core_rqm | output | 1 | Request flag to the core |
| port_p0 | output | 1 | General output pin 0 |
| port_p1 | output | 1 | General output pin 1 |

## Verification
A core load can land on the same clock edge as the host ending the read of the final byte. One side tries to set the request flag while the other clears it. The bench runs a host read task and a core load in parallel, timed so that the read strobe rises in the cycle in which the load is asserted. It judges the outcome by the byte read during the strobe, by a later status read that must show the request set with the next-byte bit clear, and by a data read that must return the low byte of the newly loaded value.

// File: rtl/hp_pkg.sv
package hp_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_DRD,
    ACC_DWR,
    ACC_SRD,
    ACC_BAD
  } acc_e;

  typedef struct packed {
    logic usf1;
    logic usf0;
    logic dma;
    logic drc;
    logic soc;
    logic sic;
    logic ei;
    logic p1;
    logic p0;
  } ctl_t;

  // classify the host strobes seen in this cycle
  function automatic acc_e hp_classify(input logic cs_n, input logic a0,
                                       input logic rd_n, input logic wr_n,
                                       input logic ack_n);
    logic dsel;
    logic ssel;
    dsel = !ack_n || (!cs_n && !a0);
    ssel = ack_n && !cs_n && a0;
    if (!(dsel || ssel))         return ACC_NONE;
    if (rd_n && wr_n)            return ACC_NONE;
    if (!rd_n && !wr_n)          return ACC_BAD;
    if (dsel && !rd_n)           return ACC_DRD;
    if (dsel && !wr_n)           return ACC_DWR;
    if (ssel && !rd_n)           return ACC_SRD;
    return ACC_BAD;              // status write is ignored
  endfunction

  // byte lane used by the next host transfer: 1 = high byte
  function automatic logic hp_lane(input logic drc, input logic drs);
    return !drc && drs;
  endfunction

  // next host transfer is the last one of the exchange
  function automatic logic hp_final(input logic drc, input logic drs);
    return drc || drs;
  endfunction

endpackage

// File: rtl/hp_bus_dec.sv
module hp_bus_dec
  import hp_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          a0,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          ack_n,
  input  logic [BW-1:0] din,
  output acc_e          acc_now,
  output logic          acc_dack,
  output logic          end_rd,
  output logic          end_wr,
  output logic [BW-1:0] wbyte
);

  acc_e          acc_q;
  logic [BW-1:0] wb_q;

  assign acc_now  = hp_classify(cs_n, a0, rd_n, wr_n, ack_n);
  assign acc_dack = !ack_n && ((acc_now == ACC_DRD) || (acc_now == ACC_DWR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= ACC_NONE;
      wb_q  <= '0;
    end else begin
      acc_q <= acc_now;
      if (acc_now == ACC_DWR) wb_q <= din;
    end
  end

  // a transfer commits on the edge where its strobe is no longer seen
  assign end_rd = (acc_q == ACC_DRD) && (acc_now != ACC_DRD);
  assign end_wr = (acc_q == ACC_DWR) && (acc_now != ACC_DWR);
  assign wbyte  = wb_q;

endmodule

// File: rtl/hp_dreg.sv
module hp_dreg
  import hp_pkg::*;
#(
  parameter int BW    = 8,
  parameter int LANES = 2,
  localparam int DW   = BW * LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_ld,
  input  logic [DW-1:0] core_ldata,
  input  logic          core_rd,
  input  logic          core_peek,
  input  logic          drc,
  input  logic          end_rd,
  input  logic          end_wr,
  input  logic [BW-1:0] wbyte,
  output logic [DW-1:0] dr,
  output logic [DW-1:0] rdata,
  output logic          rqm,
  output logic          drs
);

  logic host_done;
  logic lane;
  logic last;
  logic core_claim;

  assign host_done  = end_rd || end_wr;
  assign lane       = hp_lane(drc, drs);
  assign last       = hp_final(drc, drs);
  assign core_claim = core_ld || core_rd;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        dr[g*BW +: BW] <= '0;
      else if (core_ld)
        dr[g*BW +: BW] <= core_ldata[g*BW +: BW];
      else if (end_wr && (lane == 1'(g)))
        dr[g*BW +: BW] <= wbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rqm <= 1'b0;
      drs <= 1'b0;
    end else if (core_claim) begin
      rqm <= 1'b1;
      drs <= 1'b0;
    end else if (host_done) begin
      if (last) begin
        rqm <= 1'b0;
        drs <= 1'b0;
      end else begin
        drs <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (core_rd || core_peek)
      rdata <= dr;
  end

endmodule

// File: rtl/hp_stat.sv
module hp_stat
  import hp_pkg::*;
#(
  parameter int BW  = 8,
  localparam int DW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  ctl_t          ctl_in,
  input  logic          rqm,
  input  logic          drs,
  input  logic          acc_dack,
  output ctl_t          ctl,
  output logic [DW-1:0] stat_word,
  output logic          hreq
);

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl <= '0;
    else if (ctl_we) ctl <= ctl_in;
  end

  always_comb begin
    stat_word         = '0;
    stat_word[DW-1]   = rqm;
    stat_word[DW-2]   = ctl.usf1;
    stat_word[DW-3]   = ctl.usf0;
    stat_word[DW-4]   = drs;
    stat_word[DW-5]   = ctl.dma;
    stat_word[DW-6]   = ctl.drc;
    stat_word[DW-7]   = ctl.soc;
    stat_word[DW-8]   = ctl.sic;
    stat_word[BW-1]   = ctl.ei;
    stat_word[1]      = ctl.p1;
    stat_word[0]      = ctl.p0;
  end

  assign hreq = ctl.dma && rqm && !(acc_dack && hp_final(ctl.drc, drs));

endmodule

// File: rtl/hostport.sv
module hostport
  import hp_pkg::*;
#(
  parameter int BW  = 8,
  localparam int DW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hcs_n,
  input  logic          ha0,
  input  logic          hrd_n,
  input  logic          hwr_n,
  input  logic          hack_n,
  input  logic [BW-1:0] hdin,
  output logic [BW-1:0] hdout,
  output logic          hdoe,
  output logic          hreq,
  input  logic          core_ld,
  input  logic [DW-1:0] core_ldata,
  input  logic          core_rd,
  input  logic          core_peek,
  output logic [DW-1:0] core_rdata,
  input  logic          ctl_we,
  input  logic [8:0]    ctl_in,
  output logic [DW-1:0] stat_word,
  output logic          core_rqm,
  output logic          port_p0,
  output logic          port_p1
);

  acc_e          w_acc;
  logic          w_dack;
  logic          w_end_rd;
  logic          w_end_wr;
  logic [BW-1:0] w_wbyte;
  logic [DW-1:0] w_dr;
  logic          w_drs;
  ctl_t          w_ctl;

  hp_bus_dec #(.BW(BW)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (hcs_n),
    .a0       (ha0),
    .rd_n     (hrd_n),
    .wr_n     (hwr_n),
    .ack_n    (hack_n),
    .din      (hdin),
    .acc_now  (w_acc),
    .acc_dack (w_dack),
    .end_rd   (w_end_rd),
    .end_wr   (w_end_wr),
    .wbyte    (w_wbyte)
  );

  hp_dreg #(.BW(BW), .LANES(2)) u_dreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_ld    (core_ld),
    .core_ldata (core_ldata),
    .core_rd    (core_rd),
    .core_peek  (core_peek),
    .drc        (w_ctl.drc),
    .end_rd     (w_end_rd),
    .end_wr     (w_end_wr),
    .wbyte      (w_wbyte),
    .dr         (w_dr),
    .rdata      (core_rdata),
    .rqm        (core_rqm),
    .drs        (w_drs)
  );

  hp_stat #(.BW(BW)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_in    (ctl_t'(ctl_in)),
    .rqm       (core_rqm),
    .drs       (w_drs),
    .acc_dack  (w_dack),
    .ctl       (w_ctl),
    .stat_word (stat_word),
    .hreq      (hreq)
  );

  assign hdoe = (w_acc == ACC_DRD) || (w_acc == ACC_SRD);

  always_comb begin
    hdout = '0;
    if (w_acc == ACC_SRD)
      hdout = stat_word[DW-1 -: BW];
    else if (w_acc == ACC_DRD)
      hdout = hp_lane(w_ctl.drc, w_drs) ? w_dr[DW-1 -: BW] : w_dr[BW-1:0];
  end

  assign port_p0 = w_ctl.p0;
  assign port_p1 = w_ctl.p1;

endmodule

// File: rtl/hp_chk.sv
module hp_chk (
  input logic clk,
  input logic rst_n,
  input logic hcs_n,
  input logic hack_n,
  input logic hrd_n,
  input logic hwr_n,
  input logic hdoe,
  input logic hreq,
  input logic core_ld,
  input logic core_rd,
  input logic core_rqm,
  input logic drs,
  input logic drc,
  input logic dma,
  input logic end_rd,
  input logic end_wr
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hcs_n && hack_n) |-> !hdoe);

  a_r5_clash_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!hrd_n && !hwr_n) |-> !hdoe);

  a_r6_dack_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!hack_n && !hrd_n && hwr_n) |-> hdoe);

  a_r7_drs_two_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drs) |-> !$past(drc));

  a_r9_core_claims: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ld || core_rd) |=> (core_rqm && !drs));

  a_r10_host_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rqm) |-> $past(end_rd || end_wr));

  a_r13_drq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    hreq |-> (core_rqm && dma));

endmodule

bind hostport hp_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hcs_n    (hcs_n),
  .hack_n   (hack_n),
  .hrd_n    (hrd_n),
  .hwr_n    (hwr_n),
  .hdoe     (hdoe),
  .hreq     (hreq),
  .core_ld  (core_ld),
  .core_rd  (core_rd),
  .core_rqm (core_rqm),
  .drs      (w_drs),
  .drc      (w_ctl.drc),
  .dma      (w_ctl.dma),
  .end_rd   (w_end_rd),
  .end_wr   (w_end_wr)
);

// File: tb/test_hostport.sv
`timescale 1ns/1ps
module test_hostport;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hcs_n = 1'b1, ha0 = 1'b0, hrd_n = 1'b1, hwr_n = 1'b1, hack_n = 1'b1;
  logic [7:0]  hdin = '0;
  logic [7:0]  hdout;
  logic        hdoe, hreq;
  logic        core_ld = 1'b0, core_rd = 1'b0, core_peek = 1'b0, ctl_we = 1'b0;
  logic [15:0] core_ldata = '0;
  logic [15:0] core_rdata, stat_word;
  logic [8:0]  ctl_in = '0;
  logic        core_rqm, port_p0, port_p1;

  int nchk = 0;
  int nbad = 0;
  bit rd_live = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  hostport i_hostport (
    .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .ha0(ha0), .hrd_n(hrd_n),
    .hwr_n(hwr_n), .hack_n(hack_n), .hdin(hdin), .hdout(hdout), .hdoe(hdoe),
    .hreq(hreq), .core_ld(core_ld), .core_ldata(core_ldata), .core_rd(core_rd),
    .core_peek(core_peek), .core_rdata(core_rdata), .ctl_we(ctl_we),
    .ctl_in(ctl_in), .stat_word(stat_word), .core_rqm(core_rqm),
    .port_p0(port_p0), .port_p1(port_p1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected upper status byte, built from the R11 layout
  function automatic logic [7:0] st_hi(input bit rqm, input bit u1, input bit u0,
                                       input bit drs, input bit dma, input bit drc,
                                       input bit soc, input bit sic);
    return {rqm, u1, u0, drs, dma, drc, soc, sic};
  endfunction

  // monitor: pops one expected byte for each read strobe
  always @(negedge clk) begin
    if (rd_live) begin
      rd_live = 0;
      if (exp_q.size() == 0) begin
        nchk++; nbad++;
        $display("FAIL scoreboard empty act=%h exp=none", hdout);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {23'd0, hdoe, hdout}, {23'd0, 1'b1, e});
      end
    end
  end

  task automatic host_read(input bit via_dack, input bit a0, input logic [7:0] exp,
                           input string tag, input bit drq_low);
    @(posedge clk); #1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    if (via_dack) hack_n = 1'b0;
    else begin hcs_n = 1'b0; ha0 = a0; end
    hrd_n = 1'b0;
    rd_live = 1;
    if (drq_low) begin
      @(negedge clk);
      chk("R13 drq drop on final dack strobe", {31'd0, hreq}, 32'd0);
    end
    @(posedge clk); #1;
    hrd_n = 1'b1; hcs_n = 1'b1; hack_n = 1'b1; ha0 = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic host_write(input bit a0, input logic [7:0] d);
    @(posedge clk); #1;
    hcs_n = 1'b0; ha0 = a0; hwr_n = 1'b0; hdin = d;
    @(posedge clk); #1;
    hwr_n = 1'b1; hcs_n = 1'b1; ha0 = 1'b0; hdin = 8'h00;
    @(posedge clk); #1;
  endtask

  task automatic core_load(input logic [15:0] v);
    @(posedge clk); #1;
    core_ld = 1'b1; core_ldata = v;
    @(posedge clk); #1;
    core_ld = 1'b0;
  endtask

  task automatic core_pulse(input bit take);
    @(posedge clk); #1;
    if (take) core_rd = 1'b1; else core_peek = 1'b1;
    @(posedge clk); #1;
    core_rd = 1'b0; core_peek = 1'b0;
  endtask

  task automatic ctl_write(input logic [8:0] v);
    @(posedge clk); #1;
    ctl_we = 1'b1; ctl_in = v;
    @(posedge clk); #1;
    ctl_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset status word", {16'd0, stat_word}, 32'd0);
    chk("R9 reset request flag", {31'd0, core_rqm}, 32'd0);
    chk("R13 reset drq", {31'd0, hreq}, 32'd0);
    chk("R1 reset bus idle", {31'd0, hdoe}, 32'd0);

    // two-byte host read after a core load
    core_load(16'hA5C3);
    chk("R9 load sets request", {31'd0, core_rqm}, 32'd1);
    host_read(0, 1, st_hi(1,0,0,0,0,0,0,0), "R4 status read", 0);
    host_read(0, 0, 8'hC3, "R7 low byte first", 0);
    host_read(0, 1, st_hi(1,0,0,1,0,0,0,0), "R7 next-byte bit set", 0);
    host_read(0, 0, 8'hA5, "R3 high byte second", 0);
    chk("R10 request cleared after final byte", {31'd0, core_rqm}, 32'd0);
    host_read(0, 1, st_hi(0,0,0,0,0,0,0,0), "R7 next-byte bit cleared", 0);

    // two-byte host write
    core_pulse(1);
    chk("R9 core read sets request", {31'd0, core_rqm}, 32'd1);
    host_write(0, 8'h11);
    host_write(0, 8'h22);
    core_pulse(0);
    chk("R2 host write assembled", {16'd0, core_rdata}, 32'h2211);
    chk("R9 peek leaves request clear", {31'd0, core_rqm}, 32'd0);

    // deselected, clashing and status-write accesses are ignored
    @(posedge clk); #1;
    hrd_n = 1'b0;
    @(negedge clk);
    chk("R1 deselected read stays off bus", {31'd0, hdoe}, 32'd0);
    @(posedge clk); #1;
    hrd_n = 1'b1;
    @(posedge clk); #1;
    hcs_n = 1'b0; hrd_n = 1'b0; hwr_n = 1'b0; hdin = 8'hEE;
    @(negedge clk);
    chk("R5 clash drives nothing", {31'd0, hdoe}, 32'd0);
    @(posedge clk); #1;
    hcs_n = 1'b1; hrd_n = 1'b1; hwr_n = 1'b1; hdin = 8'h00;
    host_write(1, 8'h55);
    core_pulse(0);
    chk("R5 R4 data unchanged", {16'd0, core_rdata}, 32'h2211);
    host_read(0, 1, st_hi(0,0,0,0,0,0,0,0), "R4 status after ignored write", 0);

    // one-byte mode
    ctl_write(9'h020);
    host_read(0, 1, st_hi(0,0,0,0,0,1,0,0), "R8 width bit in status", 0);
    core_load(16'h1234);
    host_read(0, 0, 8'h34, "R8 single low byte", 0);
    chk("R8 request cleared after one byte", {31'd0, core_rqm}, 32'd0);
    host_read(0, 1, st_hi(0,0,0,0,0,1,0,0), "R8 next-byte bit stays 0", 0);
    host_write(0, 8'h77);
    core_pulse(0);
    chk("R8 write keeps high byte", {16'd0, core_rdata}, 32'h1277);

    // DMA handshake through the acknowledge
    ctl_write(9'h040);
    chk("R13 drq low while request clear", {31'd0, hreq}, 32'd0);
    core_load(16'hBEEF);
    chk("R13 drq follows request", {31'd0, hreq}, 32'd1);
    host_read(1, 1, 8'hEF, "R6 acknowledge selects data", 0);
    chk("R13 drq held after first byte", {31'd0, hreq}, 32'd1);
    host_read(1, 0, 8'hBE, "R6 acknowledge second byte", 1);
    chk("R13 drq low after exchange", {31'd0, hreq}, 32'd0);
    chk("R10 request cleared by dma", {31'd0, core_rqm}, 32'd0);

    // control layout and pins
    ctl_write(9'h116);
    chk("R11 status layout", {16'd0, stat_word}, 32'h4282);
    chk("R12 pins p1=1 p0=0", {30'd0, port_p1, port_p0}, 32'd2);
    ctl_write(9'h001);
    chk("R12 pins p1=0 p0=1", {30'd0, port_p1, port_p0}, 32'd1);
    chk("R11 status low bit", {16'd0, stat_word}, 32'h0001);

    // core load on the same edge as the final host byte
    ctl_write(9'h000);
    core_load(16'h3C5A);
    host_read(0, 0, 8'h5A, "R7 first byte before collision", 0);
    fork
      host_read(0, 0, 8'h3C, "R14 final byte read during collision", 0);
      begin
        @(posedge clk); #1;
        @(posedge clk); #1;
        core_ld = 1'b1; core_ldata = 16'h9876;
        @(posedge clk); #1;
        core_ld = 1'b0;
      end
    join
    chk("R14 request kept by core", {31'd0, core_rqm}, 32'd1);
    host_read(0, 1, st_hi(1,0,0,0,0,0,0,0), "R14 status after collision", 0);
    host_read(0, 0, 8'h76, "R14 new low byte", 0);

    @(posedge clk); #1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule